// File: doc/BRIEF.md
# Microcode Store Loader with Staged Wide-Word Commit

This block sits between a 16-bit host register bus and a 256-entry, 64-bit microcode memory that a timer sequencer reads. The host cannot write a 64-bit word in one bus cycle. It therefore fills four 16-bit staging registers and then writes a destination address to a commit register. Writing the address is what transfers the assembled word into the microcode memory. A lane-order register chooses how the four staging words map onto the 64-bit word. The choices are: the last staging word on top, the first staging word on top, or a fully byte-reversed arrangement. Software can pick whichever ordering its image format uses.

The block also owns three smaller memories used by the sequencer's datapath: a 128 x 16 shared parameter memory, a 64 x 16 scratch parameter memory and a 40 x 12 pointer table. The host can read and write them directly. A single clear command zeroes every memory one entry per cycle, in a fixed order: the microcode store, then the scratch memory, then the shared memory, then the pointer table. While that clear runs, host writes to the memories and commits are refused.

Host addresses are word addresses. Bits [11:8] select a window and bits [7:0] give the offset inside it. Reads are combinational from the address.

Top module: `mcl_loader`

## Requirements
- R1: After reset, the status register (window 0x0, offset 6) reads 0, all four staging registers (window 0x0, offsets 0 to 3) read 0, and the lane-order register (window 0x0, offset 5, bits [1:0]) reads 0.
- R2: A write to window 0x0 at offset k (k from 0 to 3) stores the 16-bit data in staging register k, and that register reads it back.
- R3: A write to the commit register (window 0x0, offset 4) with a value below 256 sets status bit 0 (commit busy) for exactly one cycle. At the end of that cycle, the microcode entry at that address holds the assembled word. A commit value of 256 or more is ignored: it raises no busy and changes no entry.
- R4: With lane order 0 or 3, the committed word is {stg3, stg2, stg1, stg0}, so staging word 3 occupies bits [63:48].
- R5: With lane order 1, the committed word is {stg0, stg1, stg2, stg3}.
- R6: With lane order 2, the committed word is the byte reversal of the order-1 word: {stg3[7:0], stg3[15:8], stg2[7:0], stg2[15:8], stg1[7:0], stg1[15:8], stg0[7:0], stg0[15:8]}.
- R7: A staging write made during the busy cycle is not part of the word being committed. It is visible in the staging register after the commit completes.
- R8: The shared memory (window 0x1, offsets 0 to 127) and the scratch memory (window 0x2, offsets 0 to 63) store and return full 16-bit words.
- R9: The pointer table (window 0x3, offsets 0 to 39) stores the low 12 bits of a write. Its reads return bits [15:12] as zero.
- R10: Offsets beyond a memory's depth, windows 0x4 to 0xF, and unassigned register offsets read as zero, and writes to them change nothing.
- R11: Writing the clear register (window 0x0, offset 7) with bit 0 set raises status bit 1 and zeroes one entry per cycle: 256 microcode entries, then 64 scratch, then 128 shared, then 40 pointer entries. Status bit 1 then drops.
- R12: While a clear runs, host writes to the memories and commit writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one word per cycle |
| host_addr | input | 12 | Host word address: window in [11:8], offset in [7:0] |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_addr (combinational) |
| seq_addr | input | 8 | Sequencer microcode read address |
| seq_data | output | 64 | Microcode word at seq_addr (combinational) |

## Verification
The hardest case to reach from the ports is the order in which the clear proceeds. The clear is only visible while it is partway through, so the bench first loads known non-zero values at the last entry of each memory. It then starts a clear and samples at fixed cycle counts that fall between the end of one phase and the end of the next. At those points it checks that earlier memories are already zero and later ones are still intact. Inside that window it also issues a memory write and a commit, to show that both are refused. The busy-cycle staging overlap is reached by placing a staging write in the cycle directly after the commit write.

// File: rtl/mcl_pkg.sv
package mcl_pkg;

    localparam int HW       = 16;
    localparam int NLANE    = 4;
    localparam int UW       = HW * NLANE;
    localparam int HOST_AW  = 12;

    localparam logic [3:0] WIN_REG = 4'h0;
    localparam logic [3:0] WIN_SH  = 4'h1;
    localparam logic [3:0] WIN_TMP = 4'h2;
    localparam logic [3:0] WIN_PT  = 4'h3;

    localparam logic [7:0] OFF_COMMIT = 8'd4;
    localparam logic [7:0] OFF_MODE   = 8'd5;
    localparam logic [7:0] OFF_STATUS = 8'd6;
    localparam logic [7:0] OFF_CLEAR  = 8'd7;

    typedef enum logic [2:0] {
        CLR_IDLE = 3'd0,
        CLR_UC   = 3'd1,
        CLR_TMP  = 3'd2,
        CLR_SH   = 3'd3,
        CLR_PT   = 3'd4
    } clr_phase_e;

    typedef enum logic [1:0] {
        LANE_HI_LAST  = 2'd0,
        LANE_HI_FIRST = 2'd1,
        LANE_BYTE_REV = 2'd2,
        LANE_SPARE    = 2'd3
    } lane_mode_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [HW-1:0] swap_bytes(input logic [HW-1:0] w);
        return {w[7:0], w[15:8]};
    endfunction

endpackage

// File: rtl/mcl_ram.sv
module mcl_ram #(
    parameter int DEPTH = 64,
    parameter int W     = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/mcl_lane_pack.sv
module mcl_lane_pack
    import mcl_pkg::*;
(
    input  logic [NLANE-1:0][HW-1:0] stg,
    input  lane_mode_e               mode,
    output logic [UW-1:0]            word
);

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        logic [HW-1:0] lane_val;
        always_comb begin
            unique case (mode)
                LANE_HI_FIRST: lane_val = stg[NLANE-1-i];
                LANE_BYTE_REV: lane_val = swap_bytes(stg[i]);
                default:       lane_val = stg[i];
            endcase
        end
        assign word[i*HW +: HW] = lane_val;
    end

endmodule

// File: rtl/mcl_loader.sv
module mcl_loader
    import mcl_pkg::*;
#(
    parameter int UC_DEPTH  = 256,
    parameter int SH_DEPTH  = 128,
    parameter int TMP_DEPTH = 64,
    parameter int PT_DEPTH  = 40,
    parameter int PT_W      = 12,
    localparam int UC_AW    = $clog2(UC_DEPTH),
    localparam int SH_AW    = $clog2(SH_DEPTH),
    localparam int TMP_AW   = $clog2(TMP_DEPTH),
    localparam int PT_AW    = $clog2(PT_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HW-1:0]      host_wdata,
    output logic [HW-1:0]      host_rdata,
    input  logic [UC_AW-1:0]   seq_addr,
    output logic [UW-1:0]      seq_data
);

    localparam int MAXD  = max_of(max_of(UC_DEPTH, SH_DEPTH), max_of(TMP_DEPTH, PT_DEPTH));
    localparam int CNT_W = $clog2(MAXD);

    localparam logic [CNT_W-1:0] UC_LAST  = CNT_W'(UC_DEPTH - 1);
    localparam logic [CNT_W-1:0] TMP_LAST = CNT_W'(TMP_DEPTH - 1);
    localparam logic [CNT_W-1:0] SH_LAST  = CNT_W'(SH_DEPTH - 1);
    localparam logic [CNT_W-1:0] PT_LAST  = CNT_W'(PT_DEPTH - 1);

    localparam logic [HW:0] UC_LIM  = (HW+1)'(UC_DEPTH);
    localparam logic [8:0]  SH_LIM  = 9'(SH_DEPTH);
    localparam logic [8:0]  TMP_LIM = 9'(TMP_DEPTH);
    localparam logic [8:0]  PT_LIM  = 9'(PT_DEPTH);

    typedef struct packed {
        logic [NLANE-1:0][HW-1:0] stg;
        lane_mode_e               mode;
        logic                     busy;
        logic [UC_AW-1:0]         cm_addr;
        clr_phase_e               phase;
        logic [CNT_W-1:0]         cnt;
    } state_t;

    state_t state_d, state_q;

    logic [3:0] win;
    logic [7:0] off;
    logic       clr_act;
    logic       sh_in, tmp_in, pt_in;
    logic       sh_hwe, tmp_hwe, pt_hwe;
    logic       host_ram_we;
    logic       cm_busy;
    clr_phase_e clr_phase;

    logic                  uc_we;
    logic [UC_AW-1:0]      uc_waddr;
    logic [UW-1:0]         uc_wdata;
    logic [UW-1:0]         packed_word;

    logic                  sh_we, tmp_we, pt_we;
    logic [SH_AW-1:0]      sh_waddr;
    logic [TMP_AW-1:0]     tmp_waddr;
    logic [PT_AW-1:0]      pt_waddr;
    logic [HW-1:0]         sh_wdata, tmp_wdata;
    logic [PT_W-1:0]       pt_wdata;
    logic [HW-1:0]         sh_rd, tmp_rd;
    logic [PT_W-1:0]       pt_rd;

    assign win       = host_addr[11:8];
    assign off       = host_addr[7:0];
    assign clr_act   = (state_q.phase != CLR_IDLE);
    assign cm_busy   = state_q.busy;
    assign clr_phase = state_q.phase;

    assign sh_in  = ({1'b0, off} < SH_LIM);
    assign tmp_in = ({1'b0, off} < TMP_LIM);
    assign pt_in  = ({1'b0, off} < PT_LIM);

    assign sh_hwe  = host_wr && (win == WIN_SH)  && sh_in  && !clr_act;
    assign tmp_hwe = host_wr && (win == WIN_TMP) && tmp_in && !clr_act;
    assign pt_hwe  = host_wr && (win == WIN_PT)  && pt_in  && !clr_act;
    assign host_ram_we = sh_hwe || tmp_hwe || pt_hwe;

    // next-state logic
    always_comb begin
        state_d      = state_q;
        state_d.busy = 1'b0;

        // clear walker
        unique case (state_q.phase)
            CLR_UC: begin
                if (state_q.cnt == UC_LAST) begin
                    state_d.phase = CLR_TMP;
                    state_d.cnt   = '0;
                end else begin
                    state_d.cnt = state_q.cnt + 1'b1;
                end
            end
            CLR_TMP: begin
                if (state_q.cnt == TMP_LAST) begin
                    state_d.phase = CLR_SH;
                    state_d.cnt   = '0;
                end else begin
                    state_d.cnt = state_q.cnt + 1'b1;
                end
            end
            CLR_SH: begin
                if (state_q.cnt == SH_LAST) begin
                    state_d.phase = CLR_PT;
                    state_d.cnt   = '0;
                end else begin
                    state_d.cnt = state_q.cnt + 1'b1;
                end
            end
            CLR_PT: begin
                if (state_q.cnt == PT_LAST) begin
                    state_d.phase = CLR_IDLE;
                    state_d.cnt   = '0;
                end else begin
                    state_d.cnt = state_q.cnt + 1'b1;
                end
            end
            default: ;
        endcase

        // host register writes
        if (host_wr && (win == WIN_REG)) begin
            if (off < 8'd4) begin
                state_d.stg[off[1:0]] = host_wdata;
            end else if (off == OFF_COMMIT) begin
                if (!clr_act && ({1'b0, host_wdata} < UC_LIM)) begin
                    state_d.busy    = 1'b1;
                    state_d.cm_addr = host_wdata[UC_AW-1:0];
                end
            end else if (off == OFF_MODE) begin
                state_d.mode = lane_mode_e'(host_wdata[1:0]);
            end else if (off == OFF_CLEAR) begin
                if (host_wdata[0] && !clr_act) begin
                    state_d.phase = CLR_UC;
                    state_d.cnt   = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{stg: '0, mode: LANE_HI_LAST, busy: 1'b0,
                         cm_addr: '0, phase: CLR_IDLE, cnt: '0};
        end else begin
            state_q <= state_d;
        end
    end

    // word assembly from the staging registers as they stand in the busy cycle
    mcl_lane_pack u_pack (
        .stg  (state_q.stg),
        .mode (state_q.mode),
        .word (packed_word)
    );

    // memory write ports: clear walker or host / commit
    assign uc_we    = (state_q.phase == CLR_UC) || state_q.busy;
    assign uc_waddr = (state_q.phase == CLR_UC) ? state_q.cnt[UC_AW-1:0] : state_q.cm_addr;
    assign uc_wdata = (state_q.phase == CLR_UC) ? '0 : packed_word;

    assign sh_we     = (state_q.phase == CLR_SH) || sh_hwe;
    assign sh_waddr  = (state_q.phase == CLR_SH) ? state_q.cnt[SH_AW-1:0] : off[SH_AW-1:0];
    assign sh_wdata  = (state_q.phase == CLR_SH) ? '0 : host_wdata;

    assign tmp_we    = (state_q.phase == CLR_TMP) || tmp_hwe;
    assign tmp_waddr = (state_q.phase == CLR_TMP) ? state_q.cnt[TMP_AW-1:0] : off[TMP_AW-1:0];
    assign tmp_wdata = (state_q.phase == CLR_TMP) ? '0 : host_wdata;

    assign pt_we     = (state_q.phase == CLR_PT) || pt_hwe;
    assign pt_waddr  = (state_q.phase == CLR_PT) ? state_q.cnt[PT_AW-1:0] : off[PT_AW-1:0];
    assign pt_wdata  = (state_q.phase == CLR_PT) ? '0 : host_wdata[PT_W-1:0];

    mcl_ram #(.DEPTH(UC_DEPTH), .W(UW)) u_uc (
        .clk(clk), .we(uc_we), .waddr(uc_waddr), .wdata(uc_wdata),
        .raddr(seq_addr), .rdata(seq_data)
    );

    mcl_ram #(.DEPTH(SH_DEPTH), .W(HW)) u_sh (
        .clk(clk), .we(sh_we), .waddr(sh_waddr), .wdata(sh_wdata),
        .raddr(off[SH_AW-1:0]), .rdata(sh_rd)
    );

    mcl_ram #(.DEPTH(TMP_DEPTH), .W(HW)) u_tmp (
        .clk(clk), .we(tmp_we), .waddr(tmp_waddr), .wdata(tmp_wdata),
        .raddr(off[TMP_AW-1:0]), .rdata(tmp_rd)
    );

    mcl_ram #(.DEPTH(PT_DEPTH), .W(PT_W)) u_pt (
        .clk(clk), .we(pt_we), .waddr(pt_waddr), .wdata(pt_wdata),
        .raddr(off[PT_AW-1:0]), .rdata(pt_rd)
    );

    // host read mux
    always_comb begin
        host_rdata = '0;
        unique case (win)
            WIN_REG: begin
                if (off < 8'd4) begin
                    host_rdata = state_q.stg[off[1:0]];
                end else if (off == OFF_MODE) begin
                    host_rdata = {{(HW-2){1'b0}}, state_q.mode};
                end else if (off == OFF_STATUS) begin
                    host_rdata = {{(HW-2){1'b0}}, clr_act, state_q.busy};
                end
            end
            WIN_SH:  if (sh_in)  host_rdata = sh_rd;
            WIN_TMP: if (tmp_in) host_rdata = tmp_rd;
            WIN_PT:  if (pt_in)  host_rdata = {{(HW-PT_W){1'b0}}, pt_rd};
            default: host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mcl_loader_chk.sv
module mcl_loader_chk
    import mcl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               host_wr,
    input logic [HOST_AW-1:0] host_addr,
    input logic [HW-1:0]      host_wdata,
    input logic [HW-1:0]      host_rdata,
    input logic               cm_busy,
    input logic               clr_act,
    input logic               host_ram_we,
    input clr_phase_e         clr_phase
);

    logic commit_try;
    assign commit_try = host_wr && (host_addr == {WIN_REG, OFF_COMMIT});

    // R3: busy lasts one cycle unless another commit is accepted
    a_r3_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_busy && !commit_try) |=> !cm_busy);

    // R3: out-of-range commit value raises no busy
    a_r3_oor_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_try && (host_wdata >= 16'd256)) |=> !cm_busy);

    // R9: pointer table reads keep the top nibble clear
    a_r9_pt_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr[11:8] == WIN_PT) |-> (host_rdata[15:12] == 4'h0));

    // R10: unassigned windows read zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr[11:8] > WIN_PT) |-> (host_rdata == '0));

    // R10: beyond the scratch depth reads zero
    a_r10_tmp_oor_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_addr[11:8] == WIN_TMP) && (host_addr[7:0] >= 8'd64)) |-> (host_rdata == '0));

    // R11: phases advance in the fixed order
    a_r11_uc_next: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_phase == CLR_UC) |=> (clr_phase inside {CLR_UC, CLR_TMP}));
    a_r11_tmp_next: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_phase == CLR_TMP) |=> (clr_phase inside {CLR_TMP, CLR_SH}));
    a_r11_sh_next: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_phase == CLR_SH) |=> (clr_phase inside {CLR_SH, CLR_PT}));
    a_r11_pt_next: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_phase == CLR_PT) |=> (clr_phase inside {CLR_PT, CLR_IDLE}));

    // R12: no host memory write and no commit while clearing
    a_r12_no_host_write: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |-> !host_ram_we);
    a_r12_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |-> !cm_busy);

endmodule

bind mcl_loader mcl_loader_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .cm_busy     (cm_busy),
    .clr_act     (clr_act),
    .host_ram_we (host_ram_we),
    .clr_phase   (clr_phase)
);

// File: tb/mcl_loader_tb.sv
module mcl_loader_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [11:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [7:0]  seq_addr = '0;
    logic [63:0] seq_data;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    logic [15:0] sh_m  [128];
    logic [15:0] tmp_m [64];
    logic [11:0] pt_m  [40];

    always #10 clk = ~clk;

    mcl_loader u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .seq_addr(seq_addr), .seq_data(seq_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] v);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    task automatic sq(input logic [7:0] a, output logic [63:0] v);
        seq_addr = a;
        #1;
        v = seq_data;
    endtask

    function automatic logic [15:0] bsw(input logic [15:0] w);
        return {w[7:0], w[15:8]};
    endfunction

    function automatic logic [63:0] expect_word(input logic [15:0] s0, input logic [15:0] s1,
                                                input logic [15:0] s2, input logic [15:0] s3,
                                                input logic [1:0] m);
        case (m)
            2'd1:    return {s0, s1, s2, s3};
            2'd2:    return {bsw(s3), bsw(s2), bsw(s1), bsw(s0)};
            default: return {s3, s2, s1, s0};
        endcase
    endfunction

    // loads staging and mode, commits, checks busy and the stored word
    task automatic load_commit(input logic [15:0] s0, input logic [15:0] s1,
                               input logic [15:0] s2, input logic [15:0] s3,
                               input logic [1:0] m, input logic [7:0] a, input string req);
        logic [15:0] v;
        logic [63:0] w;
        wr(12'h005, {14'd0, m});
        wr(12'h000, s0); wr(12'h001, s1); wr(12'h002, s2); wr(12'h003, s3);
        wr(12'h004, {8'd0, a});
        rd(12'h006, v);
        check("R3 busy raised", {48'd0, v}, 64'd1);
        @(negedge clk);
        rd(12'h006, v);
        check("R3 busy dropped", {48'd0, v}, 64'd0);
        sq(a, w);
        check(req, w, expect_word(s0, s1, s2, s3, m));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nbad++;
            nvec++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [63:0] w;
        logic [15:0] r0, r1, r2, r3;
        void'($urandom(32'd7341));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(12'h006, v); check("R1 status", {48'd0, v}, 64'd0);
        rd(12'h005, v); check("R1 mode", {48'd0, v}, 64'd0);
        for (int k = 0; k < 4; k++) begin
            rd(12'(k), v); check("R1 staging", {48'd0, v}, 64'd0);
        end

        // R2 staging readback
        wr(12'h000, 16'h1111); wr(12'h001, 16'h2222); wr(12'h002, 16'h3333); wr(12'h003, 16'h4444);
        rd(12'h000, v); check("R2 stg0", {48'd0, v}, 64'h1111);
        rd(12'h003, v); check("R2 stg3", {48'd0, v}, 64'h4444);

        // R4, R5, R6 directed orders
        load_commit(16'h0123, 16'h4567, 16'h89AB, 16'hCDEF, 2'd0, 8'd0,   "R4 order0");
        load_commit(16'h0123, 16'h4567, 16'h89AB, 16'hCDEF, 2'd1, 8'd1,   "R5 order1");
        load_commit(16'h0123, 16'h4567, 16'h89AB, 16'hCDEF, 2'd2, 8'd2,   "R6 byte reversed");
        load_commit(16'h0123, 16'h4567, 16'h89AB, 16'hCDEF, 2'd3, 8'd3,   "R4 order3 as order0");
        sq(8'd2, w); check("R6 literal", w, 64'hEFCDAB8967452301);
        load_commit(16'hAAAA, 16'hBBBB, 16'hCCCC, 16'hDDDD, 2'd0, 8'd9,   "R3 entry9");

        // R3 out-of-range commit value
        wr(12'h000, 16'h5555);
        wr(12'h004, 16'h0109);
        rd(12'h006, v); check("R3 oor no busy", {48'd0, v}, 64'd0);
        @(negedge clk);
        sq(8'd9, w); check("R3 oor entry kept", w, 64'hDDDDCCCCBBBBAAAA);

        // R7 staging write in the busy cycle
        wr(12'h005, 16'd0);
        wr(12'h000, 16'h0A0A); wr(12'h001, 16'h0B0B); wr(12'h002, 16'h0C0C); wr(12'h003, 16'h0D0D);
        wr(12'h004, 16'd20);
        wr(12'h000, 16'hFFFF);
        sq(8'd20, w); check("R7 committed old staging", w, 64'h0D0D0C0C0B0B0A0A);
        rd(12'h000, v); check("R7 staging updated", {48'd0, v}, 64'hFFFF);

        // random commits R3..R6
        for (int n = 0; n < 40; n++) begin
            r0 = 16'($urandom); r1 = 16'($urandom); r2 = 16'($urandom); r3 = 16'($urandom);
            load_commit(r0, r1, r2, r3, 2'($urandom), 8'($urandom), "R4/R5/R6 random commit");
        end

        // fill parameter memories (R8, R9)
        for (int i = 0; i < 128; i++) begin sh_m[i]  = 16'($urandom); wr(12'h100 + 12'(i), sh_m[i]); end
        for (int i = 0; i < 64;  i++) begin tmp_m[i] = 16'($urandom); wr(12'h200 + 12'(i), tmp_m[i]); end
        for (int i = 0; i < 40;  i++) begin
            v = 16'($urandom); pt_m[i] = v[11:0]; wr(12'h300 + 12'(i), v);
        end
        wr(12'h300, 16'hFFFF); pt_m[0] = 12'hFFF;
        rd(12'h300, v); check("R9 nibble dropped", {48'd0, v}, 64'h0FFF);

        // random mixed accesses R8, R9, R10
        for (int n = 0; n < 300; n++) begin
            logic [3:0]  wsel;
            logic [7:0]  o;
            logic [15:0] d, e;
            wsel = 4'(1 + ($urandom % 5));
            o    = ($urandom % 2) ? 8'($urandom % 40) : 8'($urandom);
            d    = 16'($urandom);
            if ($urandom % 2) begin
                wr({wsel, o}, d);
                if (wsel == 4'h1 && o < 128) sh_m[o[6:0]] = d;
                if (wsel == 4'h2 && o < 64)  tmp_m[o[5:0]] = d;
                if (wsel == 4'h3 && o < 40)  pt_m[o[5:0]] = d[11:0];
            end
            e = 16'd0;
            if (wsel == 4'h1 && o < 128) e = sh_m[o[6:0]];
            if (wsel == 4'h2 && o < 64)  e = tmp_m[o[5:0]];
            if (wsel == 4'h3 && o < 40)  e = {4'd0, pt_m[o[5:0]]};
            rd({wsel, o}, v);
            check("R8/R9/R10 memory access", {48'd0, v}, {48'd0, e});
        end

        // R10 unassigned register offset
        wr(12'h0F0, 16'h1234);
        rd(12'h0F0, v); check("R10 unassigned reg", {48'd0, v}, 64'd0);

        // R11/R12 clear ordering
        wr(12'h23F, 16'hA5A5);
        wr(12'h17F, 16'h5A5A);
        load_commit(16'h1, 16'h2, 16'h3, 16'h4, 2'd0, 8'd255, "R3 entry255");
        wr(12'h000, 16'h7777);
        wr(12'h007, 16'h0001);
        repeat (299) @(negedge clk);
        sq(8'd255, w);  check("R11 microcode cleared first", w, 64'd0);
        rd(12'h23F, v); check("R11 scratch not yet cleared", {48'd0, v}, 64'hA5A5);
        rd(12'h17F, v); check("R11 shared not yet cleared", {48'd0, v}, 64'h5A5A);
        rd(12'h006, v); check("R11 clear busy", {48'd0, v}, 64'd2);
        repeat (35) @(negedge clk);
        rd(12'h23F, v); check("R11 scratch cleared second", {48'd0, v}, 64'd0);
        rd(12'h17F, v); check("R11 shared still intact", {48'd0, v}, 64'h5A5A);
        wr(12'h20A, 16'hBEEF);
        wr(12'h004, 16'd7);
        rd(12'h006, v); check("R12 commit refused", {48'd0, v}, 64'd2);
        repeat (200) @(negedge clk);
        rd(12'h006, v); check("R11 clear done", {48'd0, v}, 64'd0);
        rd(12'h20A, v); check("R12 write refused", {48'd0, v}, 64'd0);
        sq(8'd7, w);    check("R12 commit refused entry", w, 64'd0);
        rd(12'h17F, v); check("R11 shared cleared", {48'd0, v}, 64'd0);
        rd(12'h327, v); check("R11 pointer cleared", {48'd0, v}, 64'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule